// File: doc/BRIEF.md
# Slow Clock Calibration Counter

This block measures how long a chosen low-frequency clock takes to complete a requested number of its own periods, counted in cycles of a fast reference clock. Three slow sources feed it: the output of the slow-clock selector, the fast RC oscillator after its divide-by-256 stage, and an external 32.768 kHz clock. Software places a source code and a slow-cycle count on the inputs and pulses a start strobe. The block then waits for the first rising edge of the chosen clock, counts reference cycles across the requested number of slow periods, and reports the raw total with a done flag. Software can then divide the total by the cycle count to obtain a period with 19 fractional bits.

A slow clock that has stopped, or is running far too slowly, must not hang the block. A second counter therefore measures reference cycles from the start strobe. Its limit is the requested slow-cycle count shifted left by an amount set by the source: a short shift for the roughly 150 kHz internal RC clock, and a longer shift for the two slower sources. If this counter reaches its limit before the measurement completes, the block raises a timeout flag and reports a result of zero.

Each slow clock is brought into the reference domain through a two-flop synchroniser. Rising edges are detected after the synchroniser.

Top module: `slowcal_counter`

## Requirements
- R1: While reset is asserted, and after it is released until the first accepted start, busy, done and timeout read 0 and the result reads 0.
- R2: A start pulse with a source code of 0, 1 or 2 while idle is accepted. From the next cycle, busy reads 1 and done, timeout and result read 0.
- R3: The source code selects which clock is measured: 0 selects the slow-clock selector output, 1 selects the RC oscillator divided by 256, and 2 selects the external 32.768 kHz clock. The two clocks that are not selected have no effect on the result.
- R4: A slow rising edge that is first sampled high at reference edge e is acted on at reference edge e+2. The first such edge acted on after the start cycle arms the counting window.
- R5: For a count N of at least 1, the result equals the number of reference cycles between the arming edge and the N-th slow rising edge after it, both as acted on. The result appears with done=1 and busy=0 in the cycle that edge is acted on.
- R6: The timeout limit is N<<10 for source 0 and N<<12 for sources 1 and 2. It is computed with 32 bits and saturates to all ones instead of wrapping.
- R7: If the number of reference cycles since the accepted start reaches the limit before the measurement completes (including when the slow clock never toggles), busy drops, timeout reads 1, done reads 0 and the result reads 0, in the cycle at start+limit.
- R8: If completion and the timeout limit fall in the same cycle, completion wins: done=1, timeout=0 and the result is valid.
- R9: A count of N=0 times out in the first cycle after the start.
- R10: Done, timeout and result hold their values until the next accepted start. A start pulse while busy is ignored and does not change the measurement in progress.
- R11: A start pulse with source code 3 is ignored: busy stays 0, and done and result keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Fast reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_mux_clk | input | 1 | Slow source 0: slow-clock selector output |
| slow_rcdiv_clk | input | 1 | Slow source 1: RC oscillator divided by 256 |
| slow_xo32k_clk | input | 1 | Slow source 2: external 32.768 kHz clock |
| cal_start | input | 1 | Start strobe, one reference cycle |
| cal_src | input | 2 | Source code (0, 1, 2; 3 is ignored) |
| cal_cycles | input | CYC_W (32) | Number of slow periods to measure |
| cal_result | output | CNT_W (32) | Reference cycles counted, 0 on timeout |
| cal_busy | output | 1 | Measurement in progress |
| cal_done | output | 1 | Measurement completed |
| cal_timeout | output | 1 | Measurement ended by the timeout limit |

## Verification
Two functions can fall in the same cycle: the completion of the N-th slow period and the timeout limit being reached. The bench restarts the selected slow clock in phase with the start strobe, so it knows that completion lands exactly d+2+N*P cycles after the start. It chooses P so that this sum equals the limit (1024 for source 0, 4096 for source 2), expects done with result N*P, and then runs with P one larger and expects a timeout at the limit cycle. Both cases are judged on the exact cycle: the flags are sampled one cycle before and at the predicted cycle.

// File: rtl/slowcal_pkg.sv
package slowcal_pkg;

   localparam int unsigned NUM_SRC = 3;

   typedef enum logic [1:0] {
      SRC_MUX   = 2'd0,
      SRC_RCDIV = 2'd1,
      SRC_XO32K = 2'd2,
      SRC_NONE  = 2'd3
   } slow_src_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ARM   = 2'd1,
      ST_COUNT = 2'd2
   } cal_state_e;

endpackage

// File: rtl/slowcal_edge_sync.sv
module slowcal_edge_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic rise_o
);

   logic [STAGES-1:0] chain;
   logic              last_q;

   initial begin
      assert (STAGES >= 2) else $fatal(1, "slowcal_edge_sync: STAGES must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain  <= '0;
         last_q <= 1'b0;
      end else begin
         chain  <= {chain[STAGES-2:0], async_in};
         last_q <= chain[STAGES-1];
      end
   end

   assign rise_o = chain[STAGES-1] & ~last_q;

   // R4
   rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o |=> !rise_o);

endmodule

// File: rtl/slowcal_limit.sv
module slowcal_limit
   import slowcal_pkg::*;
#(
   parameter int unsigned CYC_W      = 32,
   parameter int unsigned CNT_W      = 32,
   parameter int unsigned SHIFT_RC   = 10,
   parameter int unsigned SHIFT_SLOW = 12
) (
   input  logic [1:0]       src,
   input  logic [CYC_W-1:0] ncyc,
   output logic [CNT_W-1:0] limit
);

   localparam int unsigned SH_MAX = (SHIFT_RC > SHIFT_SLOW) ? SHIFT_RC : SHIFT_SLOW;
   localparam int unsigned WIDE   = CYC_W + SH_MAX;

   logic [CNT_W-1:0] cand [NUM_SRC];

   for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
      localparam int unsigned SH = (s == 0) ? SHIFT_RC : SHIFT_SLOW;
      logic [WIDE-1:0] wide;
      assign wide = {{SH_MAX{1'b0}}, ncyc} << SH;
      if (WIDE > CNT_W) begin : g_sat
         assign cand[s] = (|wide[WIDE-1:CNT_W]) ? {CNT_W{1'b1}} : wide[CNT_W-1:0];
      end else begin : g_fit
         assign cand[s] = CNT_W'(wide);
      end
   end

   always_comb begin
      case (slow_src_e'(src))
         SRC_MUX:   limit = cand[0];
         SRC_RCDIV: limit = cand[1];
         SRC_XO32K: limit = cand[2];
         default:   limit = '0;
      endcase
   end

   // R6
   limit_shift_chk: assert final ((src == 2'd3) || (ncyc == '0) || (limit != '0));

endmodule

// File: rtl/slowcal_sat_inc.sv
module slowcal_sat_inc #(
   parameter int unsigned W = 32
) (
   input  logic [W-1:0] a,
   output logic [W-1:0] y
);

   assign y = (&a) ? a : a + 1'b1;

endmodule

// File: rtl/slowcal_counter.sv
module slowcal_counter
   import slowcal_pkg::*;
#(
   parameter int unsigned CYC_W       = 32,
   parameter int unsigned CNT_W       = 32,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned SHIFT_RC    = 10,
   parameter int unsigned SHIFT_SLOW  = 12
) (
   input  logic             clk_ref,
   input  logic             rst_n,
   input  logic             slow_mux_clk,
   input  logic             slow_rcdiv_clk,
   input  logic             slow_xo32k_clk,
   input  logic             cal_start,
   input  logic [1:0]       cal_src,
   input  logic [CYC_W-1:0] cal_cycles,
   output logic [CNT_W-1:0] cal_result,
   output logic             cal_busy,
   output logic             cal_done,
   output logic             cal_timeout
);

   initial begin
      assert (SYNC_STAGES >= 2) else $fatal(1, "slowcal_counter: SYNC_STAGES below 2");
      assert (SHIFT_RC >= 1 && SHIFT_SLOW >= 1) else $fatal(1, "slowcal_counter: shifts must be positive");
      assert (CNT_W >= 2 && CYC_W >= 1) else $fatal(1, "slowcal_counter: widths too small");
   end

   // slow clock synchronisation and rising-edge detection
   logic [NUM_SRC-1:0] slow_in;
   logic [NUM_SRC-1:0] rise;

   assign slow_in = {slow_xo32k_clk, slow_rcdiv_clk, slow_mux_clk};

   for (genvar s = 0; s < NUM_SRC; s++) begin : g_sync
      slowcal_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
         .clk      (clk_ref),
         .rst_n    (rst_n),
         .async_in (slow_in[s]),
         .rise_o   (rise[s])
      );
   end

   // timeout limit for the request on the inputs
   logic [CNT_W-1:0] limit_w;

   slowcal_limit #(
      .CYC_W      (CYC_W),
      .CNT_W      (CNT_W),
      .SHIFT_RC   (SHIFT_RC),
      .SHIFT_SLOW (SHIFT_SLOW)
   ) u_limit (
      .src   (cal_src),
      .ncyc  (cal_cycles),
      .limit (limit_w)
   );

   // measurement state
   cal_state_e       state;
   slow_src_e        sel_q;
   logic [CYC_W-1:0] ncyc_q;
   logic [CNT_W-1:0] limit_q;
   logic [CNT_W-1:0] tmo_cnt;
   logic [CNT_W-1:0] ref_cnt;
   logic [CYC_W-1:0] edge_cnt;
   logic [CNT_W-1:0] result_q;
   logic             done_q;
   logic             tmo_q;

   logic [CNT_W-1:0] tmo_inc;
   logic [CNT_W-1:0] ref_inc;
   logic             sel_rise;
   logic             start_ok;
   logic             tmo_hit;
   logic             last_rise;

   slowcal_sat_inc #(.W(CNT_W)) u_tmo_inc (.a(tmo_cnt), .y(tmo_inc));
   slowcal_sat_inc #(.W(CNT_W)) u_ref_inc (.a(ref_cnt), .y(ref_inc));

   always_comb begin
      case (sel_q)
         SRC_MUX:   sel_rise = rise[0];
         SRC_RCDIV: sel_rise = rise[1];
         SRC_XO32K: sel_rise = rise[2];
         default:   sel_rise = 1'b0;
      endcase
   end

   assign start_ok  = cal_start && (cal_src != SRC_NONE);
   assign tmo_hit   = (tmo_inc >= limit_q);
   assign last_rise = sel_rise && (({1'b0, edge_cnt} + 1'b1) == {1'b0, ncyc_q});

   always_ff @(posedge clk_ref or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         sel_q    <= SRC_MUX;
         ncyc_q   <= '0;
         limit_q  <= '0;
         tmo_cnt  <= '0;
         ref_cnt  <= '0;
         edge_cnt <= '0;
         result_q <= '0;
         done_q   <= 1'b0;
         tmo_q    <= 1'b0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (start_ok) begin
                  state    <= ST_ARM;
                  sel_q    <= slow_src_e'(cal_src);
                  ncyc_q   <= cal_cycles;
                  limit_q  <= limit_w;
                  tmo_cnt  <= '0;
                  result_q <= '0;
                  done_q   <= 1'b0;
                  tmo_q    <= 1'b0;
               end
            end
            ST_ARM: begin
               tmo_cnt <= tmo_inc;
               if (tmo_hit) begin
                  state    <= ST_IDLE;
                  tmo_q    <= 1'b1;
                  result_q <= '0;
               end else if (sel_rise) begin
                  state    <= ST_COUNT;
                  ref_cnt  <= '0;
                  edge_cnt <= '0;
               end
            end
            ST_COUNT: begin
               tmo_cnt <= tmo_inc;
               if (last_rise) begin
                  state    <= ST_IDLE;
                  done_q   <= 1'b1;
                  result_q <= ref_inc;
               end else if (tmo_hit) begin
                  state    <= ST_IDLE;
                  tmo_q    <= 1'b1;
                  result_q <= '0;
               end else begin
                  ref_cnt <= ref_inc;
                  if (sel_rise) begin
                     edge_cnt <= edge_cnt + 1'b1;
                  end
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign cal_busy    = (state != ST_IDLE);
   assign cal_done    = done_q;
   assign cal_timeout = tmo_q;
   assign cal_result  = result_q;

   // R7
   flags_excl_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
      !(cal_done && cal_timeout));

   // R7
   tmo_zero_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
      cal_timeout |-> (cal_result == '0));

   // R5
   end_flag_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
      $fell(cal_busy) |-> (cal_done || cal_timeout));

   // R10
   hold_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
      (!cal_busy && !cal_start) |=> ($stable(cal_result) && $stable(cal_done) && $stable(cal_timeout)));

   // R10
   busy_ignore_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
      (cal_busy && cal_start) |=> ($stable(ncyc_q) && $stable(limit_q) && $stable(sel_q)));

   // R6
   tmo_bound_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
      cal_busy |-> (tmo_cnt <= limit_q));

   // R11
   bad_src_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
      (!cal_busy && cal_start && cal_src == 2'd3) |=> !cal_busy);

endmodule

// File: tb/slowcal_counter_test.sv
module slowcal_counter_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  sclk = 3'b000;
   logic        start = 1'b0;
   logic [1:0]  src = 2'd0;
   logic [31:0] ncyc = 32'd0;
   logic [31:0] result;
   logic        busy, done, timeout;

   int nchk = 0;
   int nerr = 0;
   int cyc  = 0;

   int per  [3];
   int gcnt [3];
   bit grun [3];

   slowcal_counter uut (
      .clk_ref        (clk),
      .rst_n          (rst_n),
      .slow_mux_clk   (sclk[0]),
      .slow_rcdiv_clk (sclk[1]),
      .slow_xo32k_clk (sclk[2]),
      .cal_start      (start),
      .cal_src        (src),
      .cal_cycles     (ncyc),
      .cal_result     (result),
      .cal_busy       (busy),
      .cal_done       (done),
      .cal_timeout    (timeout)
   );

   always #5 clk = ~clk;

   always @(posedge clk) cyc <= cyc + 1;

   // slow clock generators, updated away from the sampling edge
   always @(negedge clk) begin
      for (int s = 0; s < 3; s++) begin
         if (grun[s] && per[s] > 0) begin
            sclk[s] = (gcnt[s] >= 0) && ((gcnt[s] % per[s]) < (per[s] / 2));
            gcnt[s] = gcnt[s] + 1;
         end else begin
            sclk[s] = 1'b0;
         end
      end
   end

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // expected end offset from the start edge, flag and result, from R4-R9
   function automatic void predict(input int sel, input int n, input int p, input int d,
                                   output longint off, output bit exp_to, output longint exp_res);
      longint lim, total;
      int sh;
      sh  = (sel == 0) ? 10 : 12;
      lim = longint'(n) << sh;
      if (lim > 64'h0000_0000_FFFF_FFFF) lim = 64'h0000_0000_FFFF_FFFF;
      if (n == 0) begin
         off = 1; exp_to = 1'b1; exp_res = 0;
      end else begin
         total = (p > 0) ? (longint'(d) + 2 + longint'(n) * p) : 64'h7FFF_FFFF_FFFF;
         if (lim >= total) begin
            off = total; exp_to = 1'b0; exp_res = longint'(n) * p;
         end else begin
            off = lim; exp_to = 1'b1; exp_res = 0;
         end
      end
   endfunction

   longint last_res;
   bit     last_done;

   task automatic run_cal(input int sel, input int n, input int p, input int d,
                          input bit interfere, input string tag);
      longint off, exp_res, tend;
      bit exp_to;
      int ts;
      for (int s = 0; s < 3; s++) grun[s] = 1'b0;
      repeat (4) @(posedge clk);
      #1;
      for (int s = 0; s < 3; s++) begin
         if (s == sel) begin
            per[s] = p; gcnt[s] = -d; grun[s] = (p > 0);
         end else begin
            per[s] = 2 + int'($urandom % 30); gcnt[s] = -int'($urandom % 5); grun[s] = 1'b1;
         end
      end
      src = 2'(sel); ncyc = 32'(n); start = 1'b1;
      ts = cyc + 1;
      @(posedge clk);
      #1 start = 1'b0;
      predict(sel, n, p, d, off, exp_to, exp_res);
      tend = ts + off;
      @(negedge clk);
      // R2: accepted start clears flags and raises busy
      chk(busy && !done && !timeout && result == 0, "R2 start",
          {busy, done, timeout}, 3'b100);
      while (cyc < tend - 1) begin
         @(negedge clk);
         if (interfere && cyc == ts + 2) begin
            start = 1'b1; src = 2'((sel + 1) % 3); ncyc = 32'(n + 5);
         end else begin
            start = 1'b0;
         end
      end
      start = 1'b0;
      if (tend - 1 > ts) begin
         // R4: no end before the predicted cycle
         chk(busy && !done && !timeout, "R4 early end", {busy, done, timeout}, 3'b100);
      end
      @(negedge clk);
      chk(!busy && done == !exp_to && timeout == exp_to, {tag, " flags"},
          {busy, done, timeout}, {1'b0, !exp_to, exp_to});
      chk(result == exp_res, {tag, " result"}, result, exp_res);
      last_res  = result;
      last_done = done;
   endtask

   task automatic hold_check();
      repeat (15) @(negedge clk);
      // R10: values held while idle
      chk(!busy && done == last_done && result == last_res, "R10 hold", result, last_res);
   endtask

   initial begin
      int sel, n, p, d;
      void'($urandom(32'd4711));
      for (int s = 0; s < 3; s++) begin per[s] = 0; gcnt[s] = 0; grun[s] = 1'b0; end

      // R1: reset state
      repeat (3) @(negedge clk);
      chk(!busy && !done && !timeout && result == 0, "R1 in reset", {busy, done, timeout}, 0);
      @(posedge clk);
      #1 rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk(!busy && !done && !timeout && result == 0, "R1 after reset", result, 0);

      // R3 R5: random measurements on every source, other clocks running
      for (int i = 0; i < 30; i++) begin
         sel = int'($urandom % 3);
         n   = 1 + int'($urandom % 6);
         p   = 2 + int'($urandom % 39);
         d   = int'($urandom % p);
         run_cal(sel, n, p, d, 1'b0, "R3 R5 random");
      end
      hold_check();

      // R11: source code 3 ignored
      @(posedge clk);
      #1 begin start = 1'b1; src = 2'd3; ncyc = 32'd2; end
      @(posedge clk);
      #1 start = 1'b0;
      repeat (3) @(negedge clk);
      chk(!busy && done == last_done && result == last_res, "R11 bad source", result, last_res);

      // R10: start while busy is ignored
      run_cal(2, 4, 10, 1, 1'b1, "R10 busy start");

      // R8: completion and limit in the same cycle, completion wins
      run_cal(0, 1, 1022, 0, 1'b0, "R8 tie src0");
      run_cal(0, 1, 1023, 0, 1'b0, "R7 one past src0");
      run_cal(2, 1, 4094, 0, 1'b0, "R8 tie src2");
      run_cal(1, 1, 4095, 0, 1'b0, "R7 one past src1");

      // R7: dead clock and random slow clocks near the src0 limit
      run_cal(1, 1, 0, 0, 1'b0, "R7 dead clock");
      hold_check();
      for (int i = 0; i < 6; i++) begin
         p = 1000 + int'($urandom % 40);
         d = int'($urandom % 4);
         run_cal(0, 1, p, d, 1'b0, "R7 R6 near limit");
      end

      // R9: zero count
      run_cal(2, 0, 8, 0, 1'b0, "R9 zero count");

      // R6: a count whose shifted value overflows 32 bits must not wrap to zero
      for (int s = 0; s < 3; s++) grun[s] = 1'b0;
      @(posedge clk);
      #1 begin src = 2'd1; ncyc = 32'h0010_0000; start = 1'b1; end
      @(posedge clk);
      #1 start = 1'b0;
      repeat (60) @(negedge clk);
      chk(busy && !timeout, "R6 saturated limit", {busy, timeout}, 2'b10);

      // R1: reset during a measurement
      rst_n = 1'b0;
      @(negedge clk);
      chk(!busy && !done && !timeout && result == 0, "R1 reset mid run", {busy, done, timeout}, 0);

      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      nchk++;
      nerr++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 200000, 0);
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

endmodule